// File: doc/BRIEF.md
# DSP Control-Instruction Execution Unit

This block decodes and executes the control subset of a 16-bit DSP instruction set. The subset covers register copies, short and long immediate loads, stepping and indexed adjustment of address registers, set and clear of single status bits, and the mode-bit group that switches multiplier behaviour and accumulator width. The unit owns a file of 32 sixteen-bit registers. Slots 0 to 3 hold address registers, 4 to 7 index registers, 0x10 and 0x11 the accumulator high bytes, 0x13 the status word, 0x18 to 0x1B the auxiliary halves, 0x1C and 0x1D the accumulator low words and 0x1E and 0x1F the accumulator middle words.

Instruction words arrive on `instr_i` with a qualifying strobe. A small two-state controller drives the sequence. In `ST_EXEC` each strobed word is decoded and, if it takes one word, completes at the next clock edge. The long immediate load takes transition `T_LRI_FIRST` into `ST_WAIT_IMM`. There the unit raises a fetch request and waits for the next strobed word, which becomes the value written. Transition `T_IMM_ARRIVE` then returns to `ST_EXEC`. A read-back port gives combinational access to any register. An encoding outside the subset raises a one-cycle error pulse.

Top module: `dsp_ctl_exec`

## Requirements
- R1: After reset every register reads 0x0000, and both `fetch_req_o` and `illegal_o` are low.
- R2: Word `0001 11dd ddds ssss` copies the value read from register s into register d. A read of 0x10 or 0x11 returns the sign-extended high byte.
- R3: Word `0000 0000 100d dddd` raises `fetch_req_o` after the edge that accepts it. The request holds while no word is strobed. The next strobed word is written whole into register d, and the request drops after that edge.
- R4: Word `0000 1ddd iiii iiii` writes the 8-bit immediate, sign-extended to 16 bits, into register 0x18+d.
- R5: Status bit 14 selects 40-bit mode. When it is set, any write of value v to 0x1E (or 0x1F) by a move or load also clears 0x1C (or 0x1D) and fills 0x10 (or 0x11) with bit 15 of v. When it is clear, only the middle word changes.
- R6: Word `0000 0000 0000 01dd` decrements and `0000 0000 0000 10dd` increments address register d, modulo 2^16.
- R7: Word `0000 0000 0001 ssdd` adds index register 4+s, taken as signed, to address register d, modulo 2^16.
- R8: Word `0001 0010 0000 0iii` sets and `0001 0011 0000 0iii` clears status bit i+6.
- R9: Word `1000 aaaa xxxx xxxx` acts on the status word according to a. 0xA clears bit 13 and 0xB sets it (multiplier modify). 0xC clears bit 15 and 0xD sets it (unsigned multiply). 0xE clears bit 14 and 0xF sets it (40-bit mode). Other values of a change nothing and are legal.
- R10: Any other strobed word in `ST_EXEC` sets `illegal_o` for exactly the following cycle and leaves every register unchanged.
- R11: Registers 0x10 and 0x11 keep 8 significant bits. A write stores the low byte, and a read returns it sign-extended to 16 bits.
- R12: A single-word instruction's result is visible after the first clock edge that samples it. With the strobe low, nothing changes and `illegal_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word or long-load immediate |
| instr_valid_i | input | 1 | Qualifies `instr_i` for one cycle |
| fetch_req_o | output | 1 | High in `ST_WAIT_IMM`: the second word of a long load is awaited |
| illegal_o | output | 1 | One-cycle pulse after an unsupported encoding |
| dbg_addr_i | input | 5 | Read-back register index |
| dbg_data_o | output | 16 | Read-back value (combinational) |

## Verification
Every register update, the illegal pulse and the change of the fetch request are due one clock edge after the edge that samples the strobed word. The bench therefore drives on the falling edge and compares at the following falling edge, after its model has applied the same word. A long load takes two such steps, with any number of idle cycles in between, and the fetch request is compared on each of those cycles. Register contents are swept through the combinational read-back port inside the low half of the clock. This keeps the sweep clear of the next rising edge.

// File: rtl/dsp_ctl_pkg.sv
package dsp_ctl_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;

    // register map slots whose position the datapath relies on
    localparam logic [4:0] RA_IX_BASE = 5'h04;
    localparam logic [4:0] RA_ACH0    = 5'h10;
    localparam logic [4:0] RA_ACH1    = 5'h11;
    localparam logic [4:0] RA_SR      = 5'h13;
    localparam logic [4:0] RA_AUX     = 5'h18;
    localparam logic [4:0] RA_ACL0    = 5'h1C;
    localparam logic [4:0] RA_ACL1    = 5'h1D;
    localparam logic [4:0] RA_ACM0    = 5'h1E;
    localparam logic [4:0] RA_ACM1    = 5'h1F;

    // status word bit positions
    localparam int SRB_BASE   = 6;
    localparam int SRB_MULMOD = 13;
    localparam int SRB_WIDE   = 14;
    localparam int SRB_UNSGN  = 15;

    typedef enum logic [3:0] {
        K_MOVE,
        K_LRI,
        K_LRIS,
        K_DAR,
        K_IAR,
        K_ADDAR,
        K_SBSET,
        K_SBCLR,
        K_MODE,
        K_ILL
    } kind_e;

    typedef struct packed {
        kind_e       kind;
        logic [4:0]  dst;
        logic [4:0]  src;
        logic [15:0] imm;
    } op_t;

    typedef enum logic {
        ST_EXEC,
        ST_WAIT_IMM
    } st_e;

endpackage

// File: rtl/dsp_ctl_decode.sv
module dsp_ctl_decode
    import dsp_ctl_pkg::*;
(
    input  logic [15:0] instr_i,
    output op_t         op_o
);

    always_comb begin
        op_o.kind = K_ILL;
        op_o.dst  = '0;
        op_o.src  = '0;
        op_o.imm  = '0;
        casez (instr_i)
            16'b0000_0000_0000_01??: begin
                op_o.kind = K_DAR;
                op_o.dst  = {3'b000, instr_i[1:0]};
            end
            16'b0000_0000_0000_10??: begin
                op_o.kind = K_IAR;
                op_o.dst  = {3'b000, instr_i[1:0]};
            end
            16'b0000_0000_0001_????: begin
                op_o.kind = K_ADDAR;
                op_o.dst  = {3'b000, instr_i[1:0]};
                op_o.src  = RA_IX_BASE + {3'b000, instr_i[3:2]};
            end
            16'b0000_0000_100?_????: begin
                op_o.kind = K_LRI;
                op_o.dst  = instr_i[4:0];
            end
            16'b0000_1???_????_????: begin
                op_o.kind = K_LRIS;
                op_o.dst  = RA_AUX + {2'b00, instr_i[10:8]};
                op_o.imm  = {{8{instr_i[7]}}, instr_i[7:0]};
            end
            16'b0001_11??_????_????: begin
                op_o.kind = K_MOVE;
                op_o.dst  = instr_i[9:5];
                op_o.src  = instr_i[4:0];
            end
            16'b0001_0010_0000_0???: begin
                op_o.kind = K_SBSET;
                op_o.imm  = {13'b0, instr_i[2:0]};
            end
            16'b0001_0011_0000_0???: begin
                op_o.kind = K_SBCLR;
                op_o.imm  = {13'b0, instr_i[2:0]};
            end
            16'b1000_????_????_????: begin
                op_o.kind = K_MODE;
                op_o.imm  = {12'b0, instr_i[11:8]};
            end
            default: op_o.kind = K_ILL;
        endcase
    end

endmodule

// File: rtl/dsp_ctl_fsm.sv
module dsp_ctl_fsm
    import dsp_ctl_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic          is_lri_i,
    input  logic          is_ill_i,
    input  logic [AW-1:0] lri_dst_i,
    output logic          exec_fire_o,
    output logic          imm_fire_o,
    output logic          fetch_req_o,
    output logic          illegal_o,
    output logic [AW-1:0] pend_dst_o
);

    st_e  st_q, st_d;
    logic ill_d;
    logic cap_dst;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EXEC;
        else        st_q <= st_d;
    end

    // next state and per-state outputs
    always_comb begin
        st_d        = st_q;
        exec_fire_o = 1'b0;
        imm_fire_o  = 1'b0;
        fetch_req_o = 1'b0;
        ill_d       = 1'b0;
        cap_dst     = 1'b0;
        unique case (st_q)
            ST_EXEC: begin
                if (valid_i) begin
                    exec_fire_o = 1'b1;
                    ill_d       = is_ill_i;
                    if (is_lri_i) begin   // T_LRI_FIRST
                        st_d    = ST_WAIT_IMM;
                        cap_dst = 1'b1;
                    end
                end
            end
            ST_WAIT_IMM: begin
                fetch_req_o = 1'b1;
                if (valid_i) begin        // T_IMM_ARRIVE
                    imm_fire_o = 1'b1;
                    st_d       = ST_EXEC;
                end
            end
            default: st_d = ST_EXEC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            illegal_o  <= 1'b0;
            pend_dst_o <= '0;
        end else begin
            illegal_o <= ill_d;
            if (cap_dst) pend_dst_o <= lri_dst_i;
        end
    end

endmodule

// File: rtl/dsp_ctl_regfile.sv
module dsp_ctl_regfile
    import dsp_ctl_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int NRD = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [AW-1:0]           waddr_i,
    input  logic [DW-1:0]           wdata_i,
    input  logic                    wide_i,
    input  logic [NRD-1:0][AW-1:0]  raddr_i,
    output logic [NRD-1:0][DW-1:0]  rdata_o,
    output logic [DW-1:0]           sr_o
);

    localparam int NREG = 1 << AW;

    logic [DW-1:0] mem [NREG];
    logic [DW-1:0] nxt [NREG];
    logic          ext_act;
    logic [DW-1:0] hi_sext;
    logic [DW-1:0] hi_fill;

    assign ext_act = we_i && wide_i &&
                     (waddr_i == AW'(RA_ACM0) || waddr_i == AW'(RA_ACM1));
    assign hi_sext = {{(DW-8){wdata_i[7]}}, wdata_i[7:0]};
    assign hi_fill = {DW{wdata_i[DW-1]}};

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            nxt[i] = mem[i];
            if (we_i && waddr_i == AW'(i)) begin
                if (AW'(i) == AW'(RA_ACH0) || AW'(i) == AW'(RA_ACH1))
                    nxt[i] = hi_sext;
                else
                    nxt[i] = wdata_i;
            end else if (ext_act && waddr_i[0] == 1'(i % 2)) begin
                if (AW'(i) == AW'(RA_ACL0) || AW'(i) == AW'(RA_ACL1))
                    nxt[i] = '0;
                else if (AW'(i) == AW'(RA_ACH0) || AW'(i) == AW'(RA_ACH1))
                    nxt[i] = hi_fill;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) mem[i] <= nxt[i];
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata_o[r] = mem[raddr_i[r]];
    end

    assign sr_o = mem[AW'(RA_SR)];

endmodule

// File: rtl/dsp_ctl_exec.sv
module dsp_ctl_exec
    import dsp_ctl_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] instr_i,
    input  logic          instr_valid_i,
    output logic          fetch_req_o,
    output logic          illegal_o,
    input  logic [AW-1:0] dbg_addr_i,
    output logic [DW-1:0] dbg_data_o
);

    localparam int NRD   = 3;
    localparam int BIT_W = $clog2(DW);

    op_t                   op;
    logic                  exec_fire;
    logic                  imm_fire;
    logic [AW-1:0]         pend_dst;
    logic                  rf_we;
    logic [AW-1:0]         rf_waddr;
    logic [DW-1:0]         rf_wdata;
    logic                  rf_wide;
    logic [AW-1:0]         ra_a;
    logic [AW-1:0]         ra_b;
    logic [NRD-1:0][AW-1:0] rf_raddr;
    logic [NRD-1:0][DW-1:0] rf_rdata;
    logic [DW-1:0]         rd_a;
    logic [DW-1:0]         rd_b;
    logic [DW-1:0]         sr_q;
    logic [BIT_W-1:0]      sr_bit;
    logic [DW-1:0]         sr_mask;

    dsp_ctl_decode i_dec (
        .instr_i (instr_i),
        .op_o    (op)
    );

    dsp_ctl_fsm #(.AW(AW)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (instr_valid_i),
        .is_lri_i    (op.kind == K_LRI),
        .is_ill_i    (op.kind == K_ILL),
        .lri_dst_i   (op.dst),
        .exec_fire_o (exec_fire),
        .imm_fire_o  (imm_fire),
        .fetch_req_o (fetch_req_o),
        .illegal_o   (illegal_o),
        .pend_dst_o  (pend_dst)
    );

    assign rf_raddr = {dbg_addr_i, ra_b, ra_a};
    assign rd_a       = rf_rdata[0];
    assign rd_b       = rf_rdata[1];
    assign dbg_data_o = rf_rdata[2];

    dsp_ctl_regfile #(.DW(DW), .AW(AW), .NRD(NRD)) i_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (rf_we),
        .waddr_i (rf_waddr),
        .wdata_i (rf_wdata),
        .wide_i  (rf_wide),
        .raddr_i (rf_raddr),
        .rdata_o (rf_rdata),
        .sr_o    (sr_q)
    );

    assign sr_bit  = BIT_W'(op.imm[3:0]) + BIT_W'(SRB_BASE);
    assign sr_mask = DW'(1) << sr_bit;
    assign rf_wide = sr_q[SRB_WIDE];

    // execute datapath: one write per cycle through the register file port
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = op.dst;
        rf_wdata = '0;
        ra_a     = op.src;
        ra_b     = op.src;
        if (imm_fire) begin
            rf_we    = 1'b1;
            rf_waddr = pend_dst;
            rf_wdata = instr_i;
        end else if (exec_fire) begin
            unique case (op.kind)
                K_MOVE: begin
                    rf_we    = 1'b1;
                    rf_wdata = rd_a;
                end
                K_LRIS: begin
                    rf_we    = 1'b1;
                    rf_wdata = op.imm;
                end
                K_DAR: begin
                    ra_a     = op.dst;
                    rf_we    = 1'b1;
                    rf_wdata = rd_a - DW'(1);
                end
                K_IAR: begin
                    ra_a     = op.dst;
                    rf_we    = 1'b1;
                    rf_wdata = rd_a + DW'(1);
                end
                K_ADDAR: begin
                    ra_a     = op.dst;
                    ra_b     = op.src;
                    rf_we    = 1'b1;
                    rf_wdata = rd_a + rd_b;
                end
                K_SBSET: begin
                    rf_we    = 1'b1;
                    rf_waddr = AW'(RA_SR);
                    rf_wdata = sr_q | sr_mask;
                end
                K_SBCLR: begin
                    rf_we    = 1'b1;
                    rf_waddr = AW'(RA_SR);
                    rf_wdata = sr_q & ~sr_mask;
                end
                K_MODE: begin
                    rf_waddr = AW'(RA_SR);
                    rf_wdata = sr_q;
                    rf_we    = (op.imm[3:0] >= 4'hA);
                    case (op.imm[3:0])
                        4'hA: rf_wdata[SRB_MULMOD] = 1'b0;
                        4'hB: rf_wdata[SRB_MULMOD] = 1'b1;
                        4'hC: rf_wdata[SRB_UNSGN]  = 1'b0;
                        4'hD: rf_wdata[SRB_UNSGN]  = 1'b1;
                        4'hE: rf_wdata[SRB_WIDE]   = 1'b0;
                        4'hF: rf_wdata[SRB_WIDE]   = 1'b1;
                        default: rf_wdata = sr_q;
                    endcase
                end
                K_LRI, K_ILL: rf_we = 1'b0;
                default:      rf_we = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dsp_ctl_exec_chk.sv
module dsp_ctl_exec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] instr_i,
    input logic        instr_valid_i,
    input logic        fetch_req_o,
    input logic        illegal_o,
    input logic        rf_we,
    input logic [15:0] sr
);

    p_lri_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_i && !fetch_req_o && instr_i[15:5] == 11'b0000_0000_100) |=> fetch_req_o);

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && !instr_valid_i) |=> fetch_req_o);

    p_imm_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && instr_valid_i) |=> !fetch_req_o);

    p_ill_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ($past(instr_valid_i) && !$past(fetch_req_o)));

    p_ill_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !$past(rf_we));

    p_ill_vs_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(illegal_o && fetch_req_o));

    p_wide_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_i && !fetch_req_o && instr_i[15:8] == 8'h8F) |=> sr[14]);

    p_wide_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_i && !fetch_req_o && instr_i[15:8] == 8'h8E) |=> !sr[14]);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid_i && !fetch_req_o) |=> (!illegal_o && $stable(sr)));

endmodule

bind dsp_ctl_exec dsp_ctl_exec_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_i       (instr_i),
    .instr_valid_i (instr_valid_i),
    .fetch_req_o   (fetch_req_o),
    .illegal_o     (illegal_o),
    .rf_we         (rf_we),
    .sr            (sr_q)
);

// File: tb/test_dsp_ctl_exec.sv
`timescale 1ns/1ps
module test_dsp_ctl_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_i = 16'h0;
    logic        instr_valid_i = 1'b0;
    logic        fetch_req_o;
    logic        illegal_o;
    logic [4:0]  dbg_addr_i = 5'h0;
    logic [15:0] dbg_data_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dsp_ctl_exec i_dsp_ctl_exec (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_i       (instr_i),
        .instr_valid_i (instr_valid_i),
        .fetch_req_o   (fetch_req_o),
        .illegal_o     (illegal_o),
        .dbg_addr_i    (dbg_addr_i),
        .dbg_data_o    (dbg_data_o)
    );

    // behavioural reference state
    logic [15:0] m [32];
    bit          m_wait;
    int          m_pend;

    function automatic logic [15:0] sx8(input logic [7:0] b);
        return {{8{b[7]}}, b};
    endfunction

    task automatic m_write(input int a, input logic [15:0] v);
        bit wide;
        wide = m[19][14];
        if (a == 16 || a == 17) m[a] = sx8(v[7:0]);
        else                    m[a] = v;
        if (wide && (a == 30 || a == 31)) begin
            m[a - 2]  = 16'h0000;
            m[a - 14] = {16{v[15]}};
        end
    endtask

    task automatic m_step(input logic [15:0] w, output bit ill);
        ill = 1'b0;
        if (m_wait) begin
            m_write(m_pend, w);
            m_wait = 1'b0;
        end else if ((w & 16'hFFFC) == 16'h0004) m[int'(w[1:0])] = m[int'(w[1:0])] - 16'd1;
        else if ((w & 16'hFFFC) == 16'h0008)     m[int'(w[1:0])] = m[int'(w[1:0])] + 16'd1;
        else if ((w & 16'hFFF0) == 16'h0010)     m[int'(w[1:0])] = m[int'(w[1:0])] + m[4 + int'(w[3:2])];
        else if ((w & 16'hFFE0) == 16'h0080) begin
            m_wait = 1'b1;
            m_pend = int'(w[4:0]);
        end
        else if ((w & 16'hF800) == 16'h0800)     m_write(24 + int'(w[10:8]), sx8(w[7:0]));
        else if ((w & 16'hFC00) == 16'h1C00)     m_write(int'(w[9:5]), m[int'(w[4:0])]);
        else if ((w & 16'hFFF8) == 16'h1200)     m[19][6 + int'(w[2:0])] = 1'b1;
        else if ((w & 16'hFFF8) == 16'h1300)     m[19][6 + int'(w[2:0])] = 1'b0;
        else if ((w & 16'hF000) == 16'h8000) begin
            case (w[11:8])
                4'hA: m[19][13] = 1'b0;
                4'hB: m[19][13] = 1'b1;
                4'hC: m[19][15] = 1'b0;
                4'hD: m[19][15] = 1'b1;
                4'hE: m[19][14] = 1'b0;
                4'hF: m[19][14] = 1'b1;
                default: ;
            endcase
        end
        else ill = 1'b1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // register sweep inside the low clock phase
    task automatic scan(input string req);
        for (int a = 0; a < 32; a++) begin
            dbg_addr_i = 5'(a);
            #0.04;
            chk(dbg_data_o === m[a], req, $sformatf("reg %02h", a), dbg_data_o, m[a]);
        end
    endtask

    task automatic flags(input string req, input bit exp_ill);
        chk(illegal_o === exp_ill, req, "illegal_o", {15'b0, illegal_o}, {15'b0, exp_ill});
        chk(fetch_req_o === m_wait, req, "fetch_req_o", {15'b0, fetch_req_o}, {15'b0, m_wait});
    endtask

    task automatic send(input logic [15:0] w, input string req);
        bit ill;
        @(negedge clk);
        instr_i       = w;
        instr_valid_i = 1'b1;
        @(posedge clk);
        m_step(w, ill);
        @(negedge clk);
        instr_valid_i = 1'b0;
        instr_i       = 16'hDEAD;
        flags(req, ill);
        scan(req);
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        flags(req, 1'b0);
        scan(req);
    endtask

    task automatic lri(input logic [4:0] d, input logic [15:0] v, input string req);
        send(16'h0080 | {11'b0, d}, req);
        send(v, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 32; a++) m[a] = 16'h0000;
        m_wait = 1'b0;
        m_pend = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        idle("R1");

        // R3 long load with a stall between the two words
        send(16'h0080, "R3");
        idle("R3");
        idle("R3");
        send(16'hFFFF, "R3");
        // R6 increment wraps to zero, decrement wraps to all ones
        send(16'h0008, "R6");
        lri(5'h01, 16'h0000, "R3");
        send(16'h0005, "R6");
        send(16'h0006, "R6");
        send(16'h000A, "R6");
        // R7 signed index add with wrap
        lri(5'h06, 16'hFFFE, "R7");
        lri(5'h03, 16'h0001, "R7");
        send(16'h001B, "R7");
        send(16'h001B, "R7");
        lri(5'h04, 16'h7FFF, "R7");
        send(16'h0010, "R7");
        // R4 short loads, negative and positive
        send(16'h0A80, "R4");
        send(16'h087F, "R4");
        send(16'h0F01, "R4");
        // R2 moves, including from an accumulator high byte
        send(16'h1CBA, "R2");
        lri(5'h10, 16'h12F3, "R11");
        send(16'h1CF0, "R2");
        lri(5'h11, 16'h0071, "R11");
        // R5 16-bit mode: only the middle word changes
        lri(5'h1C, 16'hAAAA, "R5");
        send(16'h0E80, "R5");
        // R9 enter 40-bit mode, then middle-word writes extend
        send(16'h8F00, "R9");
        send(16'h0E80, "R5");
        lri(5'h1D, 16'h1234, "R5");
        lri(5'h1F, 16'h4000, "R5");
        lri(5'h1D, 16'h5555, "R5");
        send(16'h1FFA, "R5");
        send(16'h1FF8, "R5");
        lri(5'h1C, 16'h0101, "R5");
        send(16'h1F98, "R5");
        send(16'h8E00, "R9");
        send(16'h0E05, "R5");
        // R8 status bit set and clear across the whole immediate range
        for (int i = 0; i < 8; i++) send(16'h1200 | 16'(i), "R8");
        for (int i = 0; i < 8; i += 2) send(16'h1300 | 16'(i), "R8");
        // R9 mode group including no-op actions
        send(16'h8A00, "R9");
        send(16'h8B55, "R9");
        send(16'h8D00, "R9");
        send(16'h8C00, "R9");
        send(16'h8D00, "R9");
        send(16'h8300, "R9");
        send(16'h8000, "R9");
        send(16'h89FF, "R9");
        // R10 unsupported encodings, back to back and after legal words
        send(16'h0000, "R10");
        send(16'h0003, "R10");
        send(16'h0020, "R10");
        send(16'h1208, "R10");
        send(16'h0100, "R10");
        send(16'h4000, "R10");
        send(16'hFFFF, "R10");
        send(16'h0009, "R10");
        send(16'h1310, "R10");
        // R3 an illegal-looking word as the immediate is data, not an opcode
        send(16'h0093, "R3");
        send(16'hFFFF, "R3");
        // R12 idle cycles with garbage on the bus change nothing
        @(negedge clk);
        instr_i = 16'h1200;
        idle("R12");
        idle("R12");
        send(16'h0009, "R12");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule